// File: doc/BRIEF.md
# Fixed Off-Time Chopper Sequencer

This block sequences the current-chopping cycle of a full H-bridge. It runs from the internal oscillator clock. An asynchronous comparator trip comes in and passes through a two-flop synchroniser. When the trip is accepted, the source side of the bridge is switched off for a fixed off period. During that period the winding current decays. The decay is fast, slow, or fast followed by slow, as chosen by a 2-bit decay select. The decay select is captured once, when the trip is accepted.

When the off period ends, the source is enabled again and a blanking window starts. While the window is open, comparator trips are discarded, so a switching spike cannot end the on time early. The external drive controls act on the same window. A change of the direction input or a rising edge of the enable input reopens the window. Holding enable low clears it.

The block is built as a three-state machine with these states:
- `ST_DRIVE`: source on.
- `ST_FAST`: fast decay.
- `ST_SLOW`: slow decay.

The transitions are:
- trip accepted: `ST_DRIVE` goes to `ST_FAST`, or to `ST_SLOW` when the decay select gives no fast portion.
- fast portion done: `ST_FAST` goes to `ST_SLOW`.
- off period done: `ST_FAST` or `ST_SLOW` goes to `ST_DRIVE`.

Top module: `chop_sequencer`

## Requirements
- R1: Synchronous reset puts `phase_state` at drive (0). `blank_active` is high on the last reset cycle and stays high for exactly 6 cycles (`blank_sel`=0) or 12 cycles (`blank_sel`=1) in total, counting that cycle.
- R2: A one-cycle trip pulse seen while the window is closed changes `phase_state` away from drive on the third rising clock edge after the pulse is driven.
- R3: A trip that reaches the state machine while `blank_active` is high is discarded, and `phase_state` stays at drive.
- R4: The off period (`phase_state` 1 or 2) lasts exactly 96 clock cycles.
- R5: Decay select 00 gives slow decay (`phase_state`=2) for all 96 cycles.
- R6: Decay select 11 gives fast decay (`phase_state`=1) for all 96 cycles.
- R7: Decay select 01 gives 14 fast cycles, then 82 slow cycles. The off period never returns from slow to fast.
- R8: Decay select 10 gives 46 fast cycles, then 50 slow cycles.
- R9: The decay select is sampled when the trip is accepted. Changing it during the off period has no effect on that period.
- R10: When the off period ends, `phase_state` returns to drive and `blank_active` is high for exactly 6 cycles (`blank_sel`=0) or 12 cycles (`blank_sel`=1).
- R11: A change of `dir_in`, or a rising edge of `en_in`, restarts the blanking window at its full selected length from the next clock edge.
- R12: While `en_in` is low, the blanking timer is cleared and `blank_active` is low from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| trip_async | input | 1 | Comparator trip, asynchronous |
| decay_sel | input | 2 | Decay select: 00 slow, 01 short fast, 10 long fast, 11 fast |
| blank_sel | input | 1 | Blanking length select: 0 short, 1 long |
| en_in | input | 1 | External enable, used for edge and level |
| dir_in | input | 1 | External direction input |
| phase_state | output | 2 | 0 drive, 1 fast decay, 2 slow decay |
| blank_active | output | 1 | High while comparator trips are masked |

## Verification
A miscounting off-time counter changes the total length of the off period. A wrong fast threshold moves the point where the output steps from fast to slow. Either fault shows on `phase_state` within one off period, at most 96 cycles after the trip. A blanking counter with a wrong load value, or one that misses a restart or clear event, shows on `blank_active` within 12 cycles of the triggering edge. A mask that fails to discard a trip shows as an unexpected leave from drive three edges after the trip pulse. Each table pass measures the trip latency, the fast run length, the slow run length and the blank run length separately, so each of these faults is isolated.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [1:0] {
        ST_DRIVE = 2'd0,
        ST_FAST  = 2'd1,
        ST_SLOW  = 2'd2
    } chop_state_e;

    // Number of fast-decay cycles for a decay select value
    function automatic int unsigned fast_len(input logic [1:0] dsel,
                                             input int unsigned off_cycles,
                                             input int unsigned mix_short,
                                             input int unsigned mix_long);
        case (dsel)
            2'b00:   return 0;
            2'b01:   return mix_short;
            2'b10:   return mix_long;
            default: return off_cycles;
        endcase
    endfunction

endpackage

// File: rtl/chop_sync.sv
module chop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic d_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/chop_off_timer.sv
module chop_off_timer
    import chop_pkg::*;
#(
    parameter int OFF_CYCLES = 96,
    parameter int MIX_SHORT  = 14,
    parameter int MIX_LONG   = 46
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       run,
    input  logic [1:0] dsel_in,
    output logic       fast_end,
    output logic       off_last
);
    localparam int CW = $clog2(OFF_CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic [1:0]    dsel_q;
    logic [CW-1:0] fast_lim;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            dsel_q <= 2'b00;
        end else if (load) begin
            cnt_q  <= '0;
            dsel_q <= dsel_in;
        end else if (run) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign fast_lim = CW'(fast_len(dsel_q, OFF_CYCLES, MIX_SHORT, MIX_LONG));
    assign fast_end = (fast_lim != '0) && (cnt_q == fast_lim - 1'b1);
    assign off_last = (cnt_q == CW'(OFF_CYCLES - 1));

    a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q < CW'(OFF_CYCLES)));

    a_r9_dsel_held: assert property (@(posedge clk) disable iff (rst)
        (run && !load) |=> $stable(dsel_q));
endmodule

// File: rtl/chop_blank_timer.sv
module chop_blank_timer #(
    parameter int BLANK_SHORT = 6,
    parameter int BLANK_LONG  = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic start,
    input  logic len_sel,
    output logic busy
);
    localparam int BW = $clog2(BLANK_LONG + 1);

    logic [BW-1:0] cnt_q;
    logic [BW-1:0] len;

    assign len = len_sel ? BW'(BLANK_LONG) : BW'(BLANK_SHORT);

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= len;
        else if (clear)       cnt_q <= '0;
        else if (start)       cnt_q <= len;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    a_r12_clear_idles: assert property (@(posedge clk) disable iff (rst)
        clear |=> !busy);

    a_r10_len_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= BW'(BLANK_LONG));
endmodule

// File: rtl/chop_sequencer.sv
module chop_sequencer
    import chop_pkg::*;
#(
    parameter int OFF_CYCLES  = 96,
    parameter int MIX_SHORT   = 14,
    parameter int MIX_LONG    = 46,
    parameter int BLANK_SHORT = 6,
    parameter int BLANK_LONG  = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       trip_async,
    input  logic [1:0] decay_sel,
    input  logic       blank_sel,
    input  logic       en_in,
    input  logic       dir_in,
    output logic [1:0] phase_state,
    output logic       blank_active
);
    chop_state_e st_q, st_d;
    logic trip_s, blank_busy, fast_end, off_last;
    logic en_q, dir_q;
    logic trip_ok, off_done, blank_start;
    logic in_off;

    chop_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_async(trip_async), .d_sync(trip_s)
    );

    assign in_off  = (st_q != ST_DRIVE);
    assign trip_ok = trip_s && !blank_busy && (st_q == ST_DRIVE);

    chop_off_timer #(
        .OFF_CYCLES(OFF_CYCLES), .MIX_SHORT(MIX_SHORT), .MIX_LONG(MIX_LONG)
    ) u_off (
        .clk(clk), .rst(rst), .load(trip_ok), .run(in_off),
        .dsel_in(decay_sel), .fast_end(fast_end), .off_last(off_last)
    );

    // Edge detection of the external drive controls
    always_ff @(posedge clk) begin
        en_q  <= en_in;
        dir_q <= dir_in;
    end

    assign off_done    = in_off && off_last;
    assign blank_start = off_done || (en_in && !en_q) || (dir_in != dir_q);

    chop_blank_timer #(
        .BLANK_SHORT(BLANK_SHORT), .BLANK_LONG(BLANK_LONG)
    ) u_blank (
        .clk(clk), .rst(rst), .clear(!en_in), .start(blank_start),
        .len_sel(blank_sel), .busy(blank_busy)
    );

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_DRIVE: if (trip_ok)
                st_d = (fast_len(decay_sel, OFF_CYCLES, MIX_SHORT, MIX_LONG) != 0)
                       ? ST_FAST : ST_SLOW;
            ST_FAST:  if (off_last)      st_d = ST_DRIVE;
                      else if (fast_end) st_d = ST_SLOW;
            ST_SLOW:  if (off_last)      st_d = ST_DRIVE;
            default:  st_d = ST_DRIVE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_DRIVE;
        else     st_q <= st_d;
    end

    // Outputs
    always_comb begin
        phase_state  = st_q;
        blank_active = blank_busy;
    end

    a_r3_masked_trip: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DRIVE && blank_busy) |=> (st_q == ST_DRIVE));

    a_r7_no_fast_after_slow: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SLOW) |=> (st_q != ST_FAST));

    a_r10_blank_after_off: assert property (@(posedge clk) disable iff (rst)
        (in_off && off_last && en_in) |=> (blank_busy && st_q == ST_DRIVE));
endmodule

// File: tb/chop_sequencer_bench.sv
module chop_sequencer_bench;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trip_async = 1'b0;
    logic [1:0] decay_sel = 2'b00;
    logic blank_sel = 1'b1;
    logic en_in = 1'b1;
    logic dir_in = 1'b0;
    logic [1:0] phase_state;
    logic blank_active;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    chop_sequencer u_chop_sequencer (
        .clk(clk), .rst(rst), .trip_async(trip_async), .decay_sel(decay_sel),
        .blank_sel(blank_sel), .en_in(en_in), .dir_in(dir_in),
        .phase_state(phase_state), .blank_active(blank_active)
    );

    // Table: decay select, blank select, fast cycles, slow cycles, blank cycles
    localparam int V_DSEL [4] = '{0, 3, 1, 2};
    localparam int V_BSEL [4] = '{0, 1, 0, 1};
    localparam int V_FAST [4] = '{0, 96, 14, 46};
    localparam int V_SLOW [4] = '{96, 0, 82, 50};
    localparam int V_BLNK [4] = '{6, 12, 6, 12};
    localparam string V_REQ [4] = '{"R5", "R6", "R7", "R8"};

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_trip(input int dsel, input int bsel, input int fe,
                            input int se, input int be, input string req);
        int lat, f, s, b, guard;
        decay_sel = 2'(dsel);
        blank_sel = 1'(bsel);
        guard = 0;
        while (blank_active && guard < 40) begin tick(); guard++; end
        trip_async = 1'b1;
        tick();
        trip_async = 1'b0;
        lat = 1;
        while (phase_state == 2'd0 && lat < 10) begin tick(); lat++; end
        chk("R2 latency", lat, 3);
        decay_sel = ~2'(dsel);           // R9: must not alter this period
        f = 0;
        while (phase_state == 2'd1 && f < 200) begin f++; tick(); end
        s = 0;
        while (phase_state == 2'd2 && s < 200) begin s++; tick(); end
        chk({req, " R4 R9 fast"}, f, fe);
        chk({req, " R4 R9 slow"}, s, se);
        b = 0;
        while (blank_active && b < 40) begin b++; tick(); end
        chk("R10 blank after off", b, be);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int b, offs;
        repeat (3) tick();
        // R1: reset state and long blank window
        chk("R1 phase", int'(phase_state), 0);
        b = 0;
        while (blank_active && b < 40) begin
            b++;
            if (b == 1) rst = 1'b0;
            tick();
        end
        rst = 1'b0;
        chk("R1 blank len", b, 12);

        for (int i = 0; i < 4; i++)
            run_trip(V_DSEL[i], V_BSEL[i], V_FAST[i], V_SLOW[i], V_BLNK[i], V_REQ[i]);

        // R3: trip arriving inside a window opened by a direction change
        blank_sel = 1'b0;
        decay_sel = 2'b11;
        dir_in = ~dir_in;
        trip_async = 1'b1;
        tick();
        trip_async = 1'b0;
        offs = 0;
        for (int k = 0; k < 20; k++) begin
            if (phase_state != 2'd0) offs++;
            tick();
        end
        chk("R3 masked trip", offs, 0);

        // R11: direction change restarts the window
        blank_sel = 1'b1;
        dir_in = ~dir_in;
        tick();
        b = 0;
        while (blank_active && b < 40) begin b++; tick(); end
        chk("R11 dir restart", b, 12);

        // R12: enable low clears a running window
        dir_in = ~dir_in;
        tick();
        en_in = 1'b0;
        tick();
        chk("R12 enable low clears", int'(blank_active), 0);
        tick();

        // R11: enable rising edge restarts the window
        blank_sel = 1'b0;
        en_in = 1'b1;
        tick();
        b = 0;
        while (blank_active && b < 40) begin b++; tick(); end
        chk("R11 enable restart", b, 6);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule